// File: doc/BRIEF.md
# Saturating Fixed-Point Audio ALU

This block is the arithmetic stage of a 32-bit audio signal processor. It works on signed fractional data in which the most significant bit carries the sign and the value range runs from -1.0 up to just below +1.0. Each operation takes operand A, which is either an external source word or the accumulator itself. Operand B is either a second source word or a 16-bit signed immediate. The result is written into a 32-bit accumulator, and the block also keeps a zero flag and a negative flag.

A strobe qualifies each operation, and the accumulator and the flags update on the clock edge at which the strobe is high. The operation set includes addition in two forms, one that clamps at full scale and one that wraps like a counter. It also has a signed and an unsigned difference for comparisons, a fractional multiply, a left shift that clamps on overflow, two right shifts, the bitwise logic operations and negation. The surrounding core decodes instructions and supplies the operands. This block only computes the result and holds it.

Top module: `dsp_alu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator becomes 0, `zero_o` becomes 1 and `neg_o` becomes 0.
- R2: If `valid_i` is low, or `op_i` is one of the reserved codes 12 to 15, the accumulator and both flags keep their values.
- R3: Opcode 0 (clamping add) gives A+B. On signed overflow it gives 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative one, and it never wraps.
- R4: Opcode 1 (wrapping add) gives A+B modulo 2^32, so 0x7FFFFFFF+1 gives 0x80000000.
- R5: When `use_imm_i` is 1, operand B is the immediate placed in bits [31:16] with zeros in bits [15:0]. This makes it a signed fraction from -1.0 up to 1-2^-15.
- R6: Opcode 2 gives the clamped signed difference A-B, so `neg_o` is set exactly when A<B as signed numbers. Opcode 3 writes A-B modulo 2^32, sets `neg_o` to the unsigned borrow (A<B unsigned) and sets `zero_o` when A equals B.
- R7: Opcode 4 gives bits [62:31] of the signed 64-bit product A*B. The case 0x80000000*0x80000000 gives 0x7FFFFFFF, and swapping A and B does not change any result bit.
- R8: Opcode 5 shifts A left by `shamt_i` places, which multiplies it by 2^N. A count of 0 passes A unchanged. A result that does not fit in 32 bits clamps to full scale with the sign of A, and any count of 31 or more clamps every nonzero A.
- R9: Opcode 6 shifts A right by `shamt_i` places and fills with the sign bit. Opcode 7 does the same shift but fills with zeros. For counts of 32 or more the result is all sign bits for opcode 6 and 0 for opcode 7.
- R10: Opcodes 8, 9 and 10 give A AND B, A OR B and A XOR B.
- R11: Opcode 11 gives the two's-complement negation 0-A modulo 2^32, so 0x80000000 maps to itself.
- R12: When `acc_sel_i` is 1, operand A is the current accumulator and `src_a_i` is ignored.
- R13: After every write, `zero_o` is 1 exactly when the accumulator is 0. For every opcode except 3, `neg_o` equals accumulator bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| acc_sel_i | input | 1 | Use the accumulator as operand A |
| use_imm_i | input | 1 | Use the immediate as operand B |
| src_a_i | input | 32 | Source word A |
| src_b_i | input | 32 | Source word B |
| imm_i | input | 16 | Signed fractional immediate |
| shamt_i | input | 6 | Shift count |
| acc_o | output | 32 | Accumulator |
| zero_o | output | 1 | Accumulator-is-zero flag |
| neg_o | output | 1 | Negative or borrow flag |

## Verification
Some properties are checked by assertions on every cycle. These are the reset values, the hold of the accumulator when no write occurs, the flag consistency with the accumulator, the fact that a clamping add of same-signed operands and a left shift never flip the sign, and the borrow flag of the unsigned difference. The exact result values can only be shown by the bench's scenarios. These include the clamp targets, the product bit selection and the -1.0 squared case, the immediate alignment, the shift counts of 0, 31 and above, and operand-order independence of the multiply.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 16;
    localparam int SHAMT_W = 6;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_CLAMP = 4'd0,
        OP_ADD_WRAP  = 4'd1,
        OP_SUB_SGN   = 4'd2,
        OP_SUB_UNS   = 4'd3,
        OP_MUL_FRAC  = 4'd4,
        OP_SHL_CLAMP = 4'd5,
        OP_SHR_ARITH = 4'd6,
        OP_SHR_LOGIC = 4'd7,
        OP_AND       = 4'd8,
        OP_OR        = 4'd9,
        OP_XOR       = 4'd10,
        OP_NEGATE    = 4'd11
    } alu_op_e;

    // Codes 12..15 perform no write.
    function automatic logic op_writes(input logic [OP_W-1:0] code);
        return code <= OP_NEGATE;
    endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] acc,
    input  logic [IW-1:0] imm,
    input  logic          acc_sel,
    input  logic          use_imm,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb
);
    localparam int PAD_W = DW - IW;

    logic [DW-1:0] imm_aligned;

    // Immediate is left-aligned: its sign lands on the data sign bit.
    assign imm_aligned = {imm, {PAD_W{1'b0}}};

    always_comb begin
        opa = acc_sel ? acc : src_a;
        opb = use_imm ? imm_aligned : src_b;
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import dsp_alu_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SW  = 6,
    parameter int OPW = 4
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic [SW-1:0]  shamt,
    output logic [DW-1:0]  res_data,
    output logic           res_zero,
    output logic           res_neg,
    output logic           res_wr
);
    localparam int          PW   = 2 * DW;
    localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MAXN = {1'b1, {(DW-1){1'b0}}};

    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    // Saturated full-scale value for a given sign
    logic [DW-1:0] fs_by_sign;
    assign fs_by_sign = opa[DW-1] ? MAXN : MAXP;

    // Signed add and subtract with one guard bit
    logic [DW:0] sum_x, dif_x, udif_x;
    logic [DW-1:0] add_clamp, sub_clamp;
    always_comb begin
        sum_x  = {opa[DW-1], opa} + {opb[DW-1], opb};
        dif_x  = {opa[DW-1], opa} - {opb[DW-1], opb};
        udif_x = {1'b0, opa} - {1'b0, opb};
        if (sum_x[DW] != sum_x[DW-1])
            add_clamp = sum_x[DW] ? MAXN : MAXP;
        else
            add_clamp = sum_x[DW-1:0];
        if (dif_x[DW] != dif_x[DW-1])
            sub_clamp = dif_x[DW] ? MAXN : MAXP;
        else
            sub_clamp = dif_x[DW-1:0];
    end

    // Fractional multiply: drop one redundant sign bit of the product
    logic signed [PW-1:0] prod;
    logic [DW-1:0]        mul_frac;
    always_comb begin
        prod = $signed({{DW{opa[DW-1]}}, opa}) * $signed({{DW{opb[DW-1]}}, opb});
        if (opa == MAXN && opb == MAXN)
            mul_frac = MAXP;
        else
            mul_frac = prod[PW-2:DW-1];
    end

    // Clamping left shift through a double-width range check
    logic [PW-1:0] shl_wide;
    logic [DW:0]   shl_top;
    logic          shl_fits;
    logic [DW-1:0] shl_clamp;
    always_comb begin
        shl_wide = {{DW{opa[DW-1]}}, opa} << shamt;
        shl_top  = shl_wide[PW-1:DW-1];
        shl_fits = (shl_top == '0) || (shl_top == '1);
        if (int'(shamt) >= DW - 1)
            shl_clamp = (opa == '0) ? '0 : fs_by_sign;
        else if (shl_fits)
            shl_clamp = shl_wide[DW-1:0];
        else
            shl_clamp = fs_by_sign;
    end

    logic [DW-1:0] shr_a, shr_l;
    assign shr_a = DW'($signed(opa) >>> shamt);
    assign shr_l = opa >> shamt;

    always_comb begin
        res_data = '0;
        case (op_e)
            OP_ADD_CLAMP: res_data = add_clamp;
            OP_ADD_WRAP:  res_data = sum_x[DW-1:0];
            OP_SUB_SGN:   res_data = sub_clamp;
            OP_SUB_UNS:   res_data = udif_x[DW-1:0];
            OP_MUL_FRAC:  res_data = mul_frac;
            OP_SHL_CLAMP: res_data = shl_clamp;
            OP_SHR_ARITH: res_data = shr_a;
            OP_SHR_LOGIC: res_data = shr_l;
            OP_AND:       res_data = opa & opb;
            OP_OR:        res_data = opa | opb;
            OP_XOR:       res_data = opa ^ opb;
            OP_NEGATE:    res_data = '0 - opa;
            default:      res_data = '0;
        endcase
        res_wr   = op_writes(op);
        res_zero = (res_data == '0);
        res_neg  = (op_e == OP_SUB_UNS) ? udif_x[DW] : res_data[DW-1];
    end
endmodule

// File: rtl/alu_acc_reg.sv
module alu_acc_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] d_data,
    input  logic          d_zero,
    input  logic          d_neg,
    output logic [DW-1:0] q_data,
    output logic          q_zero,
    output logic          q_neg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_data <= '0;
            q_zero <= 1'b1;
            q_neg  <= 1'b0;
        end else if (wr_en) begin
            q_data <= d_data;
            q_zero <= d_zero;
            q_neg  <= d_neg;
        end
    end
endmodule

// File: rtl/dsp_alu_core.sv
module dsp_alu_core #(
    parameter int DW  = dsp_alu_pkg::DATA_W,
    parameter int IW  = dsp_alu_pkg::IMM_W,
    parameter int SW  = dsp_alu_pkg::SHAMT_W,
    parameter int OPW = dsp_alu_pkg::OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [OPW-1:0] op_i,
    input  logic           acc_sel_i,
    input  logic           use_imm_i,
    input  logic [DW-1:0]  src_a_i,
    input  logic [DW-1:0]  src_b_i,
    input  logic [IW-1:0]  imm_i,
    input  logic [SW-1:0]  shamt_i,
    output logic [DW-1:0]  acc_o,
    output logic           zero_o,
    output logic           neg_o
);
    logic [DW-1:0] opa, opb, res_data;
    logic          res_zero, res_neg, res_wr;

    alu_opnd_sel #(.DW(DW), .IW(IW)) u_sel (
        .src_a   (src_a_i),
        .src_b   (src_b_i),
        .acc     (acc_o),
        .imm     (imm_i),
        .acc_sel (acc_sel_i),
        .use_imm (use_imm_i),
        .opa     (opa),
        .opb     (opb)
    );

    alu_exec #(.DW(DW), .SW(SW), .OPW(OPW)) u_exec (
        .op       (op_i),
        .opa      (opa),
        .opb      (opb),
        .shamt    (shamt_i),
        .res_data (res_data),
        .res_zero (res_zero),
        .res_neg  (res_neg),
        .res_wr   (res_wr)
    );

    alu_acc_reg #(.DW(DW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (valid_i & res_wr),
        .d_data (res_data),
        .d_zero (res_zero),
        .d_neg  (res_neg),
        .q_data (acc_o),
        .q_zero (zero_o),
        .q_neg  (neg_o)
    );
endmodule

// File: rtl/dsp_alu_core_chk.sv
module dsp_alu_core_chk #(
    parameter int DW  = 32,
    parameter int IW  = 16,
    parameter int SW  = 6,
    parameter int OPW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           valid_i,
    input logic [OPW-1:0] op_i,
    input logic           acc_sel_i,
    input logic           use_imm_i,
    input logic [DW-1:0]  src_a_i,
    input logic [DW-1:0]  src_b_i,
    input logic [IW-1:0]  imm_i,
    input logic [SW-1:0]  shamt_i,
    input logic [DW-1:0]  acc_o,
    input logic           zero_o,
    input logic           neg_o
);
    localparam logic [OPW-1:0] C_ADDC = OPW'(0);
    localparam logic [OPW-1:0] C_SUBU = OPW'(3);
    localparam logic [OPW-1:0] C_SHLC = OPW'(5);
    localparam logic [OPW-1:0] C_LAST = OPW'(11);

    logic [DW-1:0] a_w, b_w;
    assign a_w = acc_sel_i ? acc_o : src_a_i;
    assign b_w = use_imm_i ? {imm_i, {(DW-IW){1'b0}}} : src_b_i;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (acc_o == '0) && zero_o && !neg_o);

    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        (!valid_i || op_i > C_LAST) |=> $stable(acc_o) && $stable(zero_o) && $stable(neg_o));

    a_r3_clamp_keeps_sign: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == C_ADDC && a_w[DW-1] == b_w[DW-1])
        |=> acc_o[DW-1] == $past(a_w[DW-1]));

    a_r6_borrow_flag: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == C_SUBU) |=> neg_o == ($past(a_w) < $past(b_w)));

    a_r8_shift_keeps_sign: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == C_SHLC) |=> acc_o[DW-1] == $past(a_w[DW-1]));

    a_r13_zero_flag: assert property (@(posedge clk) disable iff (rst)
        zero_o == (acc_o == '0));

    a_r13_neg_flag: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i <= C_LAST && op_i != C_SUBU) |=> neg_o == acc_o[DW-1]);
endmodule

bind dsp_alu_core dsp_alu_core_chk #(.DW(DW), .IW(IW), .SW(SW), .OPW(OPW)) u_chk (.*);

// File: tb/sim_dsp_alu_core.sv
module sim_dsp_alu_core;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        acc_sel_i = 1'b0;
    logic        use_imm_i = 1'b0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [15:0] imm_i = '0;
    logic [5:0]  shamt_i = '0;
    logic [31:0] acc_o;
    logic        zero_o, neg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #HALF clk = ~clk;

    dsp_alu_core u0 (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        ui;
        logic [5:0]  sh;
        logic [31:0] exp;
        logic        ez;
        logic        en;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t TBL [NV] = '{
        '{4'd0, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 6'd0, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd3}, // R3
        '{4'd0, 32'h80000000, 32'hC0000000, 16'h0, 1'b0, 6'd0, 32'h80000000, 1'b0, 1'b1, 8'd3}, // R3
        '{4'd0, 32'h10000000, 32'h20000000, 16'h0, 1'b0, 6'd0, 32'h30000000, 1'b0, 1'b0, 8'd3}, // R3
        '{4'd1, 32'h7FFFFFFF, 32'h00000001, 16'h0, 1'b0, 6'd0, 32'h80000000, 1'b0, 1'b1, 8'd4}, // R4
        '{4'd1, 32'hFFFFFFFF, 32'h00000001, 16'h0, 1'b0, 6'd0, 32'h00000000, 1'b1, 1'b0, 8'd4}, // R4
        '{4'd0, 32'h20000000, 32'h0, 16'h4000, 1'b1, 6'd0, 32'h60000000, 1'b0, 1'b0, 8'd5},     // R5
        '{4'd1, 32'h00000000, 32'h0, 16'h8000, 1'b1, 6'd0, 32'h80000000, 1'b0, 1'b1, 8'd5},     // R5
        '{4'd1, 32'h00000000, 32'h0, 16'h0001, 1'b1, 6'd0, 32'h00010000, 1'b0, 1'b0, 8'd5},     // R5
        '{4'd2, 32'h10000000, 32'h30000000, 16'h0, 1'b0, 6'd0, 32'hE0000000, 1'b0, 1'b1, 8'd6}, // R6
        '{4'd2, 32'h80000000, 32'h00000001, 16'h0, 1'b0, 6'd0, 32'h80000000, 1'b0, 1'b1, 8'd6}, // R6
        '{4'd3, 32'h00000001, 32'h00000002, 16'h0, 1'b0, 6'd0, 32'hFFFFFFFF, 1'b0, 1'b1, 8'd6}, // R6
        '{4'd3, 32'h80000000, 32'h00000001, 16'h0, 1'b0, 6'd0, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd6}, // R6
        '{4'd3, 32'h00000005, 32'h00000005, 16'h0, 1'b0, 6'd0, 32'h00000000, 1'b1, 1'b0, 8'd6}, // R6
        '{4'd4, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 6'd0, 32'h20000000, 1'b0, 1'b0, 8'd7}, // R7
        '{4'd4, 32'h80000000, 32'h80000000, 16'h0, 1'b0, 6'd0, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd7}, // R7
        '{4'd4, 32'h80000000, 32'h40000000, 16'h0, 1'b0, 6'd0, 32'hC0000000, 1'b0, 1'b1, 8'd7}, // R7
        '{4'd5, 32'h01000000, 32'h0, 16'h0, 1'b0, 6'd3,  32'h08000000, 1'b0, 1'b0, 8'd8},       // R8
        '{4'd5, 32'h20000000, 32'h0, 16'h0, 1'b0, 6'd2,  32'h7FFFFFFF, 1'b0, 1'b0, 8'd8},       // R8
        '{4'd5, 32'hF0000000, 32'h0, 16'h0, 1'b0, 6'd3,  32'h80000000, 1'b0, 1'b1, 8'd8},       // R8
        '{4'd5, 32'hE0000000, 32'h0, 16'h0, 1'b0, 6'd3,  32'h80000000, 1'b0, 1'b1, 8'd8},       // R8
        '{4'd5, 32'h12345678, 32'h0, 16'h0, 1'b0, 6'd0,  32'h12345678, 1'b0, 1'b0, 8'd8},       // R8
        '{4'd5, 32'h00000001, 32'h0, 16'h0, 1'b0, 6'd40, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd8},       // R8
        '{4'd5, 32'h00000000, 32'h0, 16'h0, 1'b0, 6'd31, 32'h00000000, 1'b1, 1'b0, 8'd8},       // R8
        '{4'd6, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd4,  32'hF8000000, 1'b0, 1'b1, 8'd9},       // R9
        '{4'd7, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd4,  32'h08000000, 1'b0, 1'b0, 8'd9},       // R9
        '{4'd6, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd40, 32'hFFFFFFFF, 1'b0, 1'b1, 8'd9},       // R9
        '{4'd7, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd40, 32'h00000000, 1'b1, 1'b0, 8'd9},       // R9
        '{4'd8,  32'hF0F0F0F0, 32'h0FF00FF0, 16'h0, 1'b0, 6'd0, 32'h00F000F0, 1'b0, 1'b0, 8'd10}, // R10
        '{4'd9,  32'hF0F0F0F0, 32'h0FF00FF0, 16'h0, 1'b0, 6'd0, 32'hFFF0FFF0, 1'b0, 1'b1, 8'd10}, // R10
        '{4'd10, 32'hF0F0F0F0, 32'h0FF00FF0, 16'h0, 1'b0, 6'd0, 32'hFF00FF00, 1'b0, 1'b1, 8'd10}, // R10
        '{4'd11, 32'h00000001, 32'h0, 16'h0, 1'b0, 6'd0, 32'hFFFFFFFF, 1'b0, 1'b1, 8'd11},        // R11
        '{4'd11, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd0, 32'h80000000, 1'b0, 1'b1, 8'd11}         // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic ui, input logic [5:0] sh,
                         input logic asel, input logic vld);
        @(negedge clk);
        op_i = op; src_a_i = a; src_b_i = b; imm_i = imm;
        use_imm_i = ui; shamt_i = sh; acc_sel_i = asel; valid_i = vld;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r_ab, r_ba, exp_m;
        longint      prod;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 acc after reset", acc_o, 32'h0);
        check("R1 zero flag after reset", {31'b0, zero_o}, 32'h1);
        check("R1 neg flag after reset", {31'b0, neg_o}, 32'h0);
        rst = 1'b0;

        foreach (TBL[i]) begin
            apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].imm, TBL[i].ui, TBL[i].sh, 1'b0, 1'b1);
            check($sformatf("R%0d row %0d result", TBL[i].req, i), acc_o, TBL[i].exp);
            check($sformatf("R13 row %0d zero flag", i), {31'b0, zero_o}, {31'b0, TBL[i].ez});
            check($sformatf("R13 row %0d neg flag", i), {31'b0, neg_o}, {31'b0, TBL[i].en});
        end

        // R7: operand order does not change the product
        apply(4'd4, 32'h12345678, 32'h9ABCDEF0, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        r_ab = acc_o;
        apply(4'd4, 32'h9ABCDEF0, 32'h12345678, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        r_ba = acc_o;
        prod  = longint'($signed(32'h12345678)) * longint'($signed(32'h9ABCDEF0));
        exp_m = prod[62:31];
        check("R7 product A*B", r_ab, exp_m);
        check("R7 product B*A", r_ba, r_ab);

        // R12: accumulator as operand A, src_a ignored
        apply(4'd1, 32'h00000005, 32'h0, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        apply(4'd1, 32'h00000100, 32'h00000003, 16'h0, 1'b0, 6'd0, 1'b1, 1'b1);
        check("R12 acc plus 3", acc_o, 32'h00000008);
        apply(4'd5, 32'h7FFFFFFF, 32'h0, 16'h0, 1'b0, 6'd1, 1'b1, 1'b1);
        check("R12 acc shifted", acc_o, 32'h00000010);

        // R2: no write when strobe low or opcode reserved
        apply(4'd1, 32'h11111111, 32'h11111111, 16'h0, 1'b0, 6'd0, 1'b0, 1'b0);
        apply(4'd0, 32'h00000000, 32'h00000000, 16'h0, 1'b0, 6'd0, 1'b0, 1'b0);
        check("R2 hold with strobe low", acc_o, 32'h00000010);
        check("R2 zero flag held", {31'b0, zero_o}, 32'h0);
        apply(4'd13, 32'h0, 32'h0, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        check("R2 reserved opcode 13", acc_o, 32'h00000010);
        apply(4'd15, 32'h80000000, 32'h0, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        check("R2 reserved opcode 15", acc_o, 32'h00000010);
        check("R2 neg flag held", {31'b0, neg_o}, 32'h0);

        // R1: reset again from a nonzero state
        apply(4'd11, 32'h00000001, 32'h0, 16'h0, 1'b0, 6'd0, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 acc after second reset", acc_o, 32'h0);
        check("R1 flags after second reset", {30'b0, zero_o, neg_o}, 32'h2);
        rst = 1'b0;

        finish_run();
    end
endmodule